// File: doc/BRIEF.md
# Pipelined Binary32 Multiplier

This block multiplies two IEEE-754 single-precision operands and delivers the correctly rounded single-precision product. A new operation may be presented on every clock. Each one takes exactly four clock cycles to pass through four register stages: operand decode with special-case resolution, significand multiply, normalization with exponent adjustment, and rounding with packing into the output word.

Normal and subnormal values are supported on both the input and the output side. Zeros, infinities and NaNs are resolved early and then carried along with the operation, so special results take the same number of cycles as arithmetic ones. Rounding is always to nearest, with ties going to the even significand. An enclosing datapath uses the block by presenting `a`, `b` and `in_valid`, and taking `result` in the cycle where `out_valid` is high. The block has no stall input.

Top module: `fpmul_pipe`

## Requirements
- R1: For every result that is not a NaN, the sign bit (bit 31) equals the XOR of the sign bits of `a` and `b`. This includes zero and infinity results.
- R2: If either operand has exponent field 255 and a nonzero fraction (a NaN), the result is 0x7FC00000.
- R3: If neither operand is a NaN and one operand is an infinity (exponent 255, fraction 0) while the other is a zero (exponent 0, fraction 0), the result is 0x7FC00000.
- R4: If neither operand is a NaN or a zero and at least one is an infinity, the result has exponent field 255 and fraction 0, with the sign from R1.
- R5: If neither operand is a NaN or an infinity and at least one is a zero, the result has exponent field 0 and fraction 0, with the sign from R1.
- R6: For two normal operands whose product is exactly representable, the result is that exact product. The biased exponent is eA + eB − 127, adjusted by the normalization shift.
- R7: An inexact product is rounded to the nearest representable value. A value exactly halfway between two candidates goes to the one whose fraction LSB is 0.
- R8: When rounding carries out of the significand, the fraction becomes 0 and the exponent field increments. This includes the case where the increment reaches 255 and produces an infinity.
- R9: A product whose magnitude reaches 2^128 before rounding gives a signed infinity.
- R10: A subnormal operand (exponent 0, fraction nonzero) is used with significand {0, fraction} and an effective exponent field of 1.
- R11: A product below 2^-126 is delivered as a subnormal, rounded per R7. A product that rounds below half of 2^-149, or to an even zero, gives a signed zero. A subnormal that rounds up past the largest subnormal becomes 0x00800000 (with the R1 sign).
- R12: `out_valid` is high exactly four clock edges after the edge that samples `in_valid` high, for every operand class. Back-to-back operations emerge on consecutive cycles, in order.
- R13: While `rst_n` is low, `out_valid` is 0. An operation that is in flight when reset asserts never produces an `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears stage valid bits |
| in_valid | input | 1 | Operation present on `a` and `b` this cycle |
| a | input | 32 | First binary32 operand |
| b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | `result` holds a finished product |
| result | output | 32 | Rounded binary32 product |

## Verification
The main function is tried with four groups of operands:
- exact normal products with mixed signs, which separate exponent-bias and sign errors from rounding errors;
- products built to land exactly on a halfway point with an odd and an even lower neighbour, and just below a power of two, which show whether the tie rule and the carry into the exponent are right;
- subnormal inputs and products that shrink into the subnormal range, including a tie at half the smallest subnormal and a carry into the smallest normal, which expose a missing hidden-bit rule or a wrong denormalizing shift;
- every special-case pairing, plus back-to-back streams that mix special and arithmetic operations, which shows that priority is right and that latency does not depend on the operand class.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;
  localparam int EW     = 8;
  localparam int FW     = 23;
  localparam int DW     = 1 + EW + FW;
  localparam int MW     = FW + 1;
  localparam int PW     = 2 * MW;
  localparam int XW     = EW + 4;
  localparam int LZW    = $clog2(PW + 1);
  localparam int STAGES = 4;
  localparam int BIAS   = (1 << (EW - 1)) - 1;
  localparam int EMAX   = (1 << EW) - 1;

  localparam logic signed [XW-1:0] X_ONE  = XW'(1);
  localparam logic signed [XW-1:0] X_BIAS = XW'(BIAS);
  localparam logic signed [XW-1:0] X_EMAX = XW'(EMAX);
  localparam logic signed [XW-1:0] X_PW   = XW'(PW);

  localparam logic [DW-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  typedef struct packed {
    logic                 sgn;
    logic                 spc;
    logic [DW-1:0]        spc_val;
    logic signed [XW-1:0] exp;
    logic [MW-1:0]        ma;
    logic [MW-1:0]        mb;
  } dec_t;

  typedef struct packed {
    logic                 sgn;
    logic                 spc;
    logic [DW-1:0]        spc_val;
    logic signed [XW-1:0] exp;
    logic [PW-1:0]        prod;
  } mul_t;

  typedef struct packed {
    logic          sgn;
    logic          spc;
    logic [DW-1:0] spc_val;
    logic          ovf;
    logic [EW-1:0] efield;
    logic [MW-1:0] mant;
    logic          grd;
    logic          stk;
  } nrm_t;
endpackage

// File: rtl/fpmul_decode.sv
module fpmul_decode
  import fpmul_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output dec_t          d
);
  logic [DW-1:0] op [2];
  logic [1:0]    sgn, is_zero, is_inf, is_nan;
  logic [EW-1:0] eeff [2];
  logic [MW-1:0] sig [2];

  assign op[0] = a;
  assign op[1] = b;

  for (genvar i = 0; i < 2; i++) begin : g_op
    logic [EW-1:0] ex;
    logic [FW-1:0] fr;
    assign ex         = op[i][DW-2 -: EW];
    assign fr         = op[i][FW-1:0];
    assign sgn[i]     = op[i][DW-1];
    assign is_zero[i] = (ex == '0) && (fr == '0);
    assign is_inf[i]  = (&ex) && (fr == '0);
    assign is_nan[i]  = (&ex) && (fr != '0);
    // subnormal: no hidden bit, exponent treated as 1
    assign eeff[i]    = (ex == '0) ? {{(EW-1){1'b0}}, 1'b1} : ex;
    assign sig[i]     = {(ex != '0), fr};
  end

  always_comb begin
    d.sgn = sgn[0] ^ sgn[1];
    d.ma  = sig[0];
    d.mb  = sig[1];
    d.exp = $signed({{(XW-EW){1'b0}}, eeff[0]}) +
            $signed({{(XW-EW){1'b0}}, eeff[1]}) - X_BIAS;
    d.spc     = 1'b1;
    d.spc_val = QNAN;
    if (|is_nan) begin
      d.spc_val = QNAN;
    end else if ((is_inf[0] && is_zero[1]) || (is_zero[0] && is_inf[1])) begin
      d.spc_val = QNAN;
    end else if (|is_inf) begin
      d.spc_val = {d.sgn, {EW{1'b1}}, {FW{1'b0}}};
    end else if (|is_zero) begin
      d.spc_val = {d.sgn, {(DW-1){1'b0}}};
    end else begin
      d.spc = 1'b0;
    end
  end
endmodule

// File: rtl/fpmul_norm.sv
module fpmul_norm
  import fpmul_pkg::*;
(
  input  mul_t m,
  output nrm_t n
);
  logic [LZW-1:0]       lz;
  logic                 found;
  logic [PW-1:0]        nsh, den, mask;
  logic signed [XW-1:0] e, sh;
  logic                 drop;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = PW - 1; i >= 0; i--) begin
      if (!found && m.prod[i]) found = 1'b1;
      else if (!found)         lz = lz + 1'b1;
    end
  end

  always_comb begin
    nsh  = m.prod << lz;
    // leading one now at top bit: value in [2,4) of the pre-shift scale
    e    = m.exp + X_ONE - $signed({{(XW-LZW){1'b0}}, lz});
    sh   = X_ONE - e;
    den  = '0;
    mask = '1;
    drop = 1'b0;
    n.sgn     = m.sgn;
    n.spc     = m.spc;
    n.spc_val = m.spc_val;
    n.ovf     = (e >= X_EMAX);
    if (e >= X_ONE) begin
      // efield holds e-1; the hidden bit of mant adds the missing one
      n.efield = e[EW-1:0] - {{(EW-1){1'b0}}, 1'b1};
      n.mant   = nsh[PW-1 -: MW];
      n.grd    = nsh[PW-MW-1];
      n.stk    = |nsh[PW-MW-2:0];
    end else begin
      if (sh >= X_PW) begin
        den  = '0;
        drop = |nsh;
      end else begin
        den  = nsh >> sh[LZW-1:0];
        mask = ~({PW{1'b1}} << sh[LZW-1:0]);
        drop = |(nsh & mask);
      end
      n.efield = '0;
      n.mant   = den[PW-1 -: MW];
      n.grd    = den[PW-MW-1];
      n.stk    = (|den[PW-MW-2:0]) | drop;
    end
  end
endmodule

// File: rtl/fpmul_round.sv
module fpmul_round
  import fpmul_pkg::*;
(
  input  nrm_t          n,
  output logic [DW-1:0] res
);
  logic              inc;
  logic [EW+FW-1:0]  body;

  always_comb begin
    inc  = n.grd & (n.stk | n.mant[0]);
    // carries out of the fraction fall into the exponent field
    body = {n.efield, {FW{1'b0}}} + {{(EW-1){1'b0}}, n.mant} +
           {{(EW+FW-1){1'b0}}, inc};
    if (n.spc)      res = n.spc_val;
    else if (n.ovf) res = {n.sgn, {EW{1'b1}}, {FW{1'b0}}};
    else            res = {n.sgn, body};
  end
endmodule

// File: rtl/fpmul_pipe.sv
module fpmul_pipe
  import fpmul_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  logic [STAGES-1:0] vld_q, vld_d;
  dec_t          s1_d, s1_q;
  mul_t          s2_d, s2_q;
  nrm_t          s3_d, s3_q;
  logic [DW-1:0] s4_d, s4_q;

  fpmul_decode u_dec (.a(a), .b(b), .d(s1_d));

  always_comb begin
    s2_d.sgn     = s1_q.sgn;
    s2_d.spc     = s1_q.spc;
    s2_d.spc_val = s1_q.spc_val;
    s2_d.exp     = s1_q.exp;
    s2_d.prod    = {{MW{1'b0}}, s1_q.ma} * {{MW{1'b0}}, s1_q.mb};
  end

  fpmul_norm  u_nrm (.m(s2_q), .n(s3_d));
  fpmul_round u_rnd (.n(s3_q), .res(s4_d));

  always_comb vld_d = {vld_q[STAGES-2:0], in_valid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid) s1_q <= s1_d;
    if (vld_q[0]) s2_q <= s2_d;
    if (vld_q[1]) s3_q <= s3_d;
    if (vld_q[2]) s4_q <= s4_d;
  end

  assign out_valid = vld_q[STAGES-1];
  assign result    = s4_q;
endmodule

// File: rtl/fpmul_pipe_chk.sv
module fpmul_pipe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] a,
  input logic [31:0] b,
  input logic        out_valid,
  input logic [31:0] result
);
  logic [2:0] warm;
  logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, any_nan, inv, any_inf;

  assign a_nan   = (&a[30:23]) && (|a[22:0]);
  assign b_nan   = (&b[30:23]) && (|b[22:0]);
  assign a_inf   = (&a[30:23]) && !(|a[22:0]);
  assign b_inf   = (&b[30:23]) && !(|b[22:0]);
  assign a_zero  = !(|a[30:0]);
  assign b_zero  = !(|b[30:0]);
  assign any_nan = a_nan | b_nan;
  assign inv     = !any_nan && ((a_inf && b_zero) || (a_zero && b_inf));
  assign any_inf = !any_nan && !a_zero && !b_zero && (a_inf || b_inf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            warm <= '0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end

  p_reset_clear_r13: assert property (@(posedge clk) !rst_n |-> !out_valid);

  p_no_early_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 3'd4) |-> !out_valid);

  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  p_nan_canon_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&result[30:23]) && (|result[22:0])) |-> (result == 32'h7FC00000));

  p_nan_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm == 3'd4) && $past(in_valid, 4) && $past(any_nan, 4)) |-> (result == 32'h7FC00000));

  p_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm == 3'd4) && $past(in_valid, 4) && $past(inv, 4)) |-> (result == 32'h7FC00000));

  p_inf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm == 3'd4) && $past(in_valid, 4) && $past(any_inf, 4)) |-> (result[30:0] == 31'h7F800000));

  p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm == 3'd4) && $past(in_valid, 4) && !$past(any_nan | inv, 4))
      |-> (result[31] == $past(a[31] ^ b[31], 4)));
endmodule

bind fpmul_pipe fpmul_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
  .out_valid(out_valid), .result(result)
);

// File: tb/fpmul_pipe_bench.sv
module fpmul_pipe_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, in_valid;
  logic [31:0] a, b;
  logic        out_valid;
  logic [31:0] result;
  int          total = 0;
  int          bad = 0;

  fpmul_pipe u_fpmul_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one isolated operation: output must appear after the fourth edge, not the third
  task automatic run_op(input logic [31:0] x, input logic [31:0] y,
                        input logic [31:0] exp, input string tag);
    @(negedge clk); a = x; b = y; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk); chk({tag, " R12 not yet valid"}, {31'b0, out_valid}, 32'd0);
    @(negedge clk); chk({tag, " R12 valid"}, {31'b0, out_valid}, 32'd1);
    chk(tag, result, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; a = '0; b = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R13 out_valid in reset", {31'b0, out_valid}, 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk); chk("R13 out_valid after release", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_exact;
    run_op(32'h3FC00000, 32'h40000000, 32'h40400000, "R6 1.5*2");
    run_op(32'hC0000000, 32'h40400000, 32'hC0C00000, "R6 R1 -2*3");
    run_op(32'h40400000, 32'h40400000, 32'h41100000, "R6 3*3");
  endtask

  task automatic t_nan;
    run_op(32'h7F800001, 32'h3F800000, 32'h7FC00000, "R2 snan*1");
    run_op(32'hFFC00000, 32'h00000000, 32'h7FC00000, "R2 -nan*0");
    run_op(32'h7F800000, 32'h7FC12345, 32'h7FC00000, "R2 inf*nan");
  endtask

  task automatic t_invalid;
    run_op(32'h7F800000, 32'h80000000, 32'h7FC00000, "R3 inf*-0");
    run_op(32'h80000000, 32'hFF800000, 32'h7FC00000, "R3 -0*-inf");
  endtask

  task automatic t_inf;
    run_op(32'h7F800000, 32'hC0000000, 32'hFF800000, "R4 R1 inf*-2");
    run_op(32'hFF800000, 32'h00000001, 32'hFF800000, "R4 -inf*subnormal");
  endtask

  task automatic t_zero;
    run_op(32'h00000000, 32'hC0400000, 32'h80000000, "R5 R1 0*-3");
    run_op(32'h80000000, 32'h80000000, 32'h00000000, "R5 R1 -0*-0");
  endtask

  task automatic t_round;
    run_op(32'h3F800001, 32'h3FC00000, 32'h3FC00002, "R7 tie odd rounds up");
    run_op(32'h3F800003, 32'h3FC00000, 32'h3FC00004, "R7 tie even stays");
  endtask

  task automatic t_carry;
    run_op(32'h3FFFFFFE, 32'h3F800001, 32'h40000000, "R8 carry into exponent");
    run_op(32'h7F7FFFFE, 32'h3F800001, 32'h7F800000, "R8 R9 carry to infinity");
  endtask

  task automatic t_overflow;
    run_op(32'h7F7FFFFF, 32'h40000000, 32'h7F800000, "R9 max*2");
    run_op(32'hFF7FFFFF, 32'h7F7FFFFF, 32'hFF800000, "R9 R1 -max*max");
  endtask

  task automatic t_sub_in;
    run_op(32'h00000001, 32'h4B000000, 32'h00800000, "R10 min_sub*2^23");
    run_op(32'h00400000, 32'h3F800000, 32'h00400000, "R10 sub*1");
    run_op(32'h00000003, 32'h4B800000, 32'h01C00000, "R10 3*min_sub*2^24");
  endtask

  task automatic t_sub_out;
    run_op(32'h1F800000, 32'h17800000, 32'h00000020, "R11 2^-64*2^-80");
    run_op(32'h80000001, 32'h3F000000, 32'h80000000, "R11 tie to signed zero");
    run_op(32'h00000001, 32'h3F400000, 32'h00000001, "R11 round up to min_sub");
    run_op(32'h80000001, 32'h00000001, 32'h80000000, "R11 deep underflow");
    run_op(32'h007FFFFF, 32'h3F800001, 32'h00800000, "R11 carry to min normal");
  endtask

  task automatic t_stream;
    @(negedge clk); a = 32'h3FC00000; b = 32'h40000000; in_valid = 1'b1;
    @(negedge clk); a = 32'h7F800000; b = 32'hC0000000;
    @(negedge clk); a = 32'h00000000; b = 32'hC0400000;
    @(negedge clk); in_valid = 1'b0;
    chk("R12 stream not yet valid", {31'b0, out_valid}, 32'd0);
    @(negedge clk); chk("R12 stream v0", {31'b0, out_valid}, 32'd1);
    chk("R12 stream r0", result, 32'h40400000);
    @(negedge clk); chk("R12 stream v1", {31'b0, out_valid}, 32'd1);
    chk("R12 stream r1", result, 32'hFF800000);
    @(negedge clk); chk("R12 stream v2", {31'b0, out_valid}, 32'd1);
    chk("R12 stream r2", result, 32'h80000000);
    @(negedge clk); chk("R12 stream end", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_reset_mid;
    @(negedge clk); a = 32'h3FC00000; b = 32'h40000000; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); chk("R13 flushed op stays invisible", {31'b0, out_valid}, 32'd0);
    end
  endtask

  initial begin
    t_reset();
    t_exact();
    t_nan();
    t_invalid();
    t_inf();
    t_zero();
    t_round();
    t_carry();
    t_overflow();
    t_sub_in();
    t_sub_out();
    t_stream();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule